// File: doc/BRIEF.md
# Line-Buffered Debug Byte Logger

This block gathers characters that a host writes one byte at a time and assembles them into a text line in an internal byte store. A line is closed when the host writes a line-feed (0x0A), or when the store has only its final slot left. Closing a line writes a zero byte after the stored text. It then announces the line to a consumer with a one-cycle start pulse and a length. The consumer reads the stored bytes through a synchronous read port and returns a done pulse, which reopens the block for the next line.

While a line is waiting for the consumer, the host side is held off through a ready signal. A byte the host keeps offering is therefore neither lost nor reordered; it becomes the first character of the following line.

The controller has three states:
- `ST_FILL` accepts bytes.
- `ST_ANNOUNCE` lasts one cycle and drives the start pulse.
- `ST_HOLD` waits for the done pulse.

Its transitions are:
- FILL→ANNOUNCE when a terminating byte is accepted.
- ANNOUNCE→HOLD always.
- HOLD→FILL on the done pulse.
- Any state→FILL on synchronous reset.

Top module: `linebuf_logger`

## Requirements
- R1: After synchronous reset `wr_ready` is 1, `line_start` is 0, and the next line is stored starting at index 0.
- R2: A byte accepted in ST_FILL that does not end the line is stored at the current write offset, and the offset then grows by one, so a line's bytes sit at indices 0, 1, 2, … in arrival order.
- R3: An accepted byte of value 0x0A ends the line and is not stored; `line_len` equals the number of bytes stored before it.
- R4: When DEPTH-1 bytes are stored, the next accepted byte of any value ends the line and is discarded; `line_len` is then DEPTH-1.
- R5: A 0x0A accepted at offset 0 still produces an announcement, with `line_len` 0.
- R6: `line_start` is high for exactly one cycle, the cycle after the terminating byte is accepted, and `line_len` is valid in that cycle.
- R7: From acceptance of a terminating byte until a `line_done` pulse in ST_HOLD, `wr_ready` is 0 and `line_len` holds. A byte held on `wr_valid` during that time is accepted once `wr_ready` returns, and becomes index 0 of the next line.
- R8: A `line_done` pulse while in ST_FILL has no effect on `wr_ready`, `line_start` or the line being built.
- R9: Synchronous reset during ST_HOLD aborts the emission: `wr_ready` returns to 1 and the next line starts at index 0.
- R10: A zero byte is stored at index `line_len` when a line ends. `rd_data` shows the byte at `rd_addr` one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host offers a byte |
| wr_data | input | 8 | Byte offered by the host |
| wr_ready | output | 1 | Block can take a byte this cycle |
| line_start | output | 1 | One-cycle pulse announcing a finished line |
| line_len | output | $clog2(DEPTH) | Number of text bytes in the announced line |
| line_done | input | 1 | Consumer has finished with the line |
| rd_addr | input | $clog2(DEPTH) | Read index into the byte store |
| rd_data | output | 8 | Byte at the previous cycle's `rd_addr` |

## Verification
The hardest situation to reach is the full-store close (R4). The host must push exactly DEPTH-1 bytes with no line-feed among them, and then one more byte. That last byte may have any value, including 0x00, 0x0A or 0xFF, and it must vanish.

The bench uses a depth of 8 so this boundary is reached quickly. It sweeps every line length from 0 to 7, drives runs longer than the store, and varies the dropped byte.

A second hard case holds a byte on `wr_valid` through the whole announce-and-hold window, which shows that back-pressure neither loses nor reorders data.

// File: rtl/lbl_pkg.sv
package lbl_pkg;
    typedef enum logic [1:0] {
        ST_FILL     = 2'd0,
        ST_ANNOUNCE = 2'd1,
        ST_HOLD     = 2'd2
    } lbl_state_e;

    localparam logic [7:0] LINE_FEED = 8'h0A;
    localparam logic [7:0] TERM_BYTE = 8'h00;
endpackage

// File: rtl/lbl_cursor.sv
module lbl_cursor #(
    parameter int DEPTH = 4096,
    localparam int LW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          clr,
    output logic [LW-1:0] offset,
    output logic          at_last
);
    localparam logic [LW-1:0] LAST_IDX = LW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            offset <= '0;
        end else if (inc) begin
            offset <= offset + 1'b1;
        end
    end

    assign at_last = (offset == LAST_IDX);
endmodule

// File: rtl/lbl_store.sv
module lbl_store #(
    parameter int DEPTH = 4096,
    localparam int LW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [LW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [LW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/lbl_ctrl.sv
module lbl_ctrl
    import lbl_pkg::*;
#(
    parameter int DEPTH = 4096,
    localparam int LW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    input  logic          line_done,
    input  logic [LW-1:0] offset,
    input  logic          at_last,
    output logic          wr_ready,
    output logic          line_start,
    output logic [LW-1:0] line_len,
    output logic          st_we,
    output logic [7:0]    st_wdata,
    output logic          cur_inc,
    output logic          cur_clr
);
    lbl_state_e state, state_nx;
    logic       take;
    logic       ends_line;

    assign take      = (state == ST_FILL) && wr_valid;
    assign ends_line = take && ((wr_data == LINE_FEED) || at_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            line_len <= '0;
        end else begin
            state <= state_nx;
            if (ends_line) begin
                line_len <= offset;
            end
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_FILL:     if (ends_line) state_nx = ST_ANNOUNCE;
            ST_ANNOUNCE: state_nx = ST_HOLD;
            ST_HOLD:     if (line_done) state_nx = ST_FILL;
            default:     state_nx = ST_FILL;
        endcase
    end

    always_comb begin
        wr_ready   = (state == ST_FILL);
        line_start = (state == ST_ANNOUNCE);
        st_we      = take;
        st_wdata   = ends_line ? TERM_BYTE : wr_data;
        cur_inc    = take && !ends_line;
        cur_clr    = ends_line;
    end
endmodule

// File: rtl/linebuf_logger.sv
module linebuf_logger #(
    parameter int DEPTH = 4096,
    localparam int LW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_valid,
    input  logic [7:0]    wr_data,
    output logic          wr_ready,
    output logic          line_start,
    output logic [LW-1:0] line_len,
    input  logic          line_done,
    input  logic [LW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [LW-1:0] offset;
    logic          at_last;
    logic          st_we;
    logic [7:0]    st_wdata;
    logic          cur_inc;
    logic          cur_clr;

    lbl_cursor #(.DEPTH(DEPTH)) u_cursor (
        .clk     (clk),
        .rst     (rst),
        .inc     (cur_inc),
        .clr     (cur_clr),
        .offset  (offset),
        .at_last (at_last)
    );

    lbl_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .wr_valid   (wr_valid),
        .wr_data    (wr_data),
        .line_done  (line_done),
        .offset     (offset),
        .at_last    (at_last),
        .wr_ready   (wr_ready),
        .line_start (line_start),
        .line_len   (line_len),
        .st_we      (st_we),
        .st_wdata   (st_wdata),
        .cur_inc    (cur_inc),
        .cur_clr    (cur_clr)
    );

    lbl_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (st_we),
        .waddr (offset),
        .wdata (st_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );
endmodule

// File: rtl/lbl_checker.sv
module lbl_checker #(
    parameter int DEPTH = 4096,
    localparam int LW = $clog2(DEPTH)
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_valid,
    input logic [7:0]    wr_data,
    input logic          wr_ready,
    input logic          line_start,
    input logic [LW-1:0] line_len,
    input logic          line_done
);
    AST_RESET_READY: assert property (@(posedge clk) $fell(rst) |-> wr_ready); // R1
    AST_LF_ANNOUNCES: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && wr_ready && wr_data == 8'h0A) |=> line_start); // R3
    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start); // R6
    AST_START_AFTER_TAKE: assert property (@(posedge clk) disable iff (rst)
        line_start |-> $past(wr_valid && wr_ready)); // R6
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && !line_done) |=> !wr_ready); // R7
    AST_LEN_HELD: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && !line_start) |-> $stable(line_len)); // R7
    AST_RESUME_ON_DONE: assert property (@(posedge clk) disable iff (rst)
        (!wr_ready && !line_start && line_done) |=> wr_ready); // R7
    AST_DONE_IN_FILL: assert property (@(posedge clk) disable iff (rst)
        (wr_ready && !wr_valid && line_done) |=> (wr_ready && !line_start)); // R8
endmodule

bind linebuf_logger lbl_checker #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/sim_linebuf_logger.sv
module sim_linebuf_logger;
    localparam int D  = 8;
    localparam int LW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [7:0]    wr_data = 8'h00;
    logic          wr_ready;
    logic          line_start;
    logic [LW-1:0] line_len;
    logic          line_done = 1'b0;
    logic [LW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] mdl [D];
    int mlen = 0;

    always #5 clk = ~clk;

    linebuf_logger #(.DEPTH(D)) u0 (
        .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_ready(wr_ready), .line_start(line_start), .line_len(line_len),
        .line_done(line_done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mlen = 0;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        while (!wr_ready) @(negedge clk);
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
    endtask

    // Called right after the terminating byte was taken.
    task automatic check_line(input string tag);
        @(negedge clk);
        check(line_start == 1'b1, "R6 start pulse", int'(line_start), 1);
        check(int'(line_len) == mlen, tag, int'(line_len), mlen);
        @(negedge clk);
        check(line_start == 1'b0, "R6 pulse width", int'(line_start), 0);
        check(wr_ready == 1'b0, "R7 ready low in hold", int'(wr_ready), 0);
        for (int i = 0; i <= mlen; i++) begin
            rd_addr = LW'(i);
            @(negedge clk);
            if (i == mlen)
                check(rd_data == 8'h00, "R10 zero terminator", int'(rd_data), 0);
            else
                check(rd_data == mdl[i], "R2 stored byte", int'(rd_data), int'(mdl[i]));
        end
        line_done = 1'b1;
        @(negedge clk);
        line_done = 1'b0;
        check(wr_ready == 1'b1, "R7 ready after done", int'(wr_ready), 1);
        mlen = 0;
    endtask

    task automatic feed(input logic [7:0] b);
        if (b == 8'h0A || mlen == D - 1) begin
            string tag;
            if (mlen == D - 1)  tag = "R4 full close length";
            else if (mlen == 0) tag = "R5 empty line length";
            else                tag = "R3 line-feed length";
            put(b);
            check_line(tag);
        end else begin
            mdl[mlen] = b;
            mlen++;
            put(b);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        check(wr_ready == 1'b1, "R1 ready after reset", int'(wr_ready), 1);
        check(line_start == 1'b0, "R1 no start after reset", int'(line_start), 0);

        // R2 R3 R5: every length from 0 to D-1 closed by a line-feed
        for (int n = 0; n < D; n++) begin
            for (int i = 0; i < n; i++) feed(8'(8'h20 + n * 8 + i));
            feed(8'h0A);
        end

        // R4: runs longer than the store
        for (int i = 0; i < D + 3; i++) feed(8'(8'h61 + i));
        feed(8'h0A);

        // R4: the discarded byte takes several values
        foreach (mdl[k]) begin end
        for (int v = 0; v < 4; v++) begin
            logic [7:0] drop;
            drop = (v == 0) ? 8'h00 : (v == 1) ? 8'hFF : (v == 2) ? 8'h0A : 8'h41;
            for (int i = 0; i < D - 1; i++) feed(8'(8'h30 + v + i));
            feed(drop);
        end

        // R8: done pulse while filling is ignored
        feed(8'h4D);
        feed(8'h4E);
        @(negedge clk);
        line_done = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(wr_ready == 1'b1 && line_start == 1'b0, "R8 done ignored in fill",
                  int'({wr_ready, line_start}), 2);
        end
        line_done = 1'b0;
        feed(8'h4F);
        feed(8'h0A);

        // R7: byte held through announce and hold
        feed(8'h78);
        feed(8'h79);
        put(8'h0A);
        @(negedge clk);
        check(line_start == 1'b1 && int'(line_len) == 2, "R3 len before stall",
              int'(line_len), 2);
        wr_valid = 1'b1;
        wr_data  = 8'h51;
        repeat (3) begin
            @(negedge clk);
            check(wr_ready == 1'b0, "R7 stalled", int'(wr_ready), 0);
            check(int'(line_len) == 2, "R7 len held", int'(line_len), 2);
        end
        line_done = 1'b1;
        @(posedge clk);
        #1;
        line_done = 1'b0;
        @(posedge clk);
        #1;
        wr_valid = 1'b0;
        mlen = 1;
        mdl[0] = 8'h51;
        feed(8'h52);
        feed(8'h0A);

        // R9: reset during hold aborts the emission
        feed(8'h61);
        feed(8'h62);
        put(8'h0A);
        repeat (2) @(negedge clk);
        check(wr_ready == 1'b0, "R9 in hold before reset", int'(wr_ready), 0);
        do_reset();
        @(negedge clk);
        check(wr_ready == 1'b1, "R9 ready after abort", int'(wr_ready), 1);
        check(line_start == 1'b0, "R1 no start after abort", int'(line_start), 0);
        feed(8'h43);
        feed(8'h0A);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule